// File: doc/BRIEF.md
# Accumulator ALU with carry and zero flags

This block is the arithmetic and logic stage of a small accumulator machine. On each valid cycle it takes an operation code, the accumulator value, a register operand, a 4-bit immediate with a select bit, and the present carry and zero flags. It computes the new data value, the new carry and zero values, and one write enable each for the result, the carry flag and the zero flag. Outputs are registered, so they appear one clock after the inputs are presented. The register file and the instruction decoder sit outside the block. They use the enables to decide which state to update.

The operations are add with carry, increment, decrement, AND, OR, complement, rotate left and right through carry, circular rotate left and right, invert carry and clear carry. Each operation has its own rule for which flags it writes. Flags that are not written are passed through unchanged on the flag outputs, so the consumer can load them without qualification.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, `out_valid`, `result`, `result_we`, `carry_out`, `carry_we`, `zero_out` and `zero_we` are all 0. Every later result appears on the clock edge that follows the edge sampling `in_valid`=1.
- R2: Add with carry (op=0x0) gives result = (acc + source + carry_in) mod 256. It sets carry to the ninth sum bit and zero to (result==0), and asserts all three write enables.
- R3: When `use_imm`=1, the source for add (0x0), AND (0x3) and OR (0x4) is `imm` zero-extended to 8 bits, and `opnd` is ignored. For increment, decrement and complement, `use_imm` and `imm` have no effect.
- R4: Increment (op=0x1) gives opnd+1 mod 256. Carry is 1 only when opnd was 0xFF, and zero is (result==0). All three enables are asserted.
- R5: Decrement (op=0x2) gives opnd−1 mod 256. Carry is 1 as a borrow only when opnd was 0x00, and zero is (result==0). All three enables are asserted.
- R6: AND (op=0x3) and OR (op=0x4) combine acc with the source. They clear carry, set zero to (result==0), and assert all three enables.
- R7: Complement (op=0x5) gives the bitwise inverse of opnd with `result_we`=1. Both flag enables are 0.
- R8: Rotate left through carry (op=0x6) gives {acc[6:0], carry_in} with carry = acc[7]. Rotate right through carry (op=0x7) gives {carry_in, acc[7:1]} with carry = acc[0]. Only the result and carry enables are asserted.
- R9: Circular rotate left (op=0x8) gives {acc[6:0], acc[7]}. Circular rotate right (op=0x9) gives {acc[0], acc[7:1]}. Neither flag enable is asserted.
- R10: Invert carry (op=0xA) drives carry to the inverse of carry_in, and clear carry (op=0xB) drives it to 0. Each asserts only `carry_we`.
- R11: A flag whose enable is 0 on a valid output equals the matching input flag sampled with the operation. Codes 0xC–0xF assert no write enable.
- R12: When `in_valid`=0 on an edge, the following `out_valid` and all three write enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs hold an operation this cycle |
| op | input | 4 | Operation code |
| use_imm | input | 1 | Take the zero-extended immediate as source |
| acc | input | 8 | Accumulator value |
| opnd | input | 8 | Selected register value |
| imm | input | 4 | Immediate data |
| carry_in | input | 1 | Present carry flag |
| zero_in | input | 1 | Present zero flag |
| out_valid | output | 1 | Registered outputs hold a result |
| result | output | 8 | Data value to write back |
| result_we | output | 1 | Write enable for the data value |
| carry_out | output | 1 | New carry flag |
| carry_we | output | 1 | Write enable for the carry flag |
| zero_out | output | 1 | New zero flag |
| zero_we | output | 1 | Write enable for the zero flag |

## Verification
Add is driven with operands whose sum lands exactly on 0x100, stays below it, and saturates with a carry-in. This separates the ninth sum bit from the zero test and shows that carry_in takes part. Increment and decrement are tried at their wrap points and just beside them, so a carry tied to the wrong edge shows up. Rotates use patterns with set end bits and a carry that differs from the bit it displaces, which makes a rotate through carry distinguishable from a circular one. Immediate tests put a different value on `opnd` at the same time, so the source mux is exposed. Flag pass-through is checked with input flags set opposite to what the operation would have produced.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADC  = 4'h0,
        OP_INC  = 4'h1,
        OP_DEC  = 4'h2,
        OP_AND  = 4'h3,
        OP_OR   = 4'h4,
        OP_CPL  = 4'h5,
        OP_RLC  = 4'h6,
        OP_RRC  = 4'h7,
        OP_ROL  = 4'h8,
        OP_ROR  = 4'h9,
        OP_CMC  = 4'hA,
        OP_CLC  = 4'hB
    } op_e;

    typedef enum logic [1:0] {
        CLS_ARITH,
        CLS_LOGIC,
        CLS_SHIFT,
        CLS_NONE
    } op_class_e;

    // Flag values and write enables produced by one unit.
    typedef struct packed {
        logic c;
        logic z;
        logic rwe;
        logic cwe;
        logic zwe;
    } flag_upd_t;

    localparam flag_upd_t UPD_NONE = '{c: 1'b0, z: 1'b0, rwe: 1'b0, cwe: 1'b0, zwe: 1'b0};

    function automatic op_class_e class_of(input op_e code);
        case (code)
            OP_ADC, OP_INC, OP_DEC:           class_of = CLS_ARITH;
            OP_AND, OP_OR, OP_CPL:            class_of = CLS_LOGIC;
            OP_RLC, OP_RRC, OP_ROL, OP_ROR,
            OP_CMC, OP_CLC:                   class_of = CLS_SHIFT;
            default:                          class_of = CLS_NONE;
        endcase
    endfunction

    function automatic flag_upd_t upd_full(input logic c, input logic z);
        upd_full = '{c: c, z: z, rwe: 1'b1, cwe: 1'b1, zwe: 1'b1};
    endfunction

endpackage

// File: rtl/acc_alu_arith.sv
module acc_alu_arith
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] opnd,
    input  logic             cin,
    output logic [WIDTH-1:0] data,
    output flag_upd_t        upd
);
    localparam int EXT_W = WIDTH + 1;

    logic [EXT_W-1:0] sum_ext;
    logic [EXT_W-1:0] inc_ext;
    logic [EXT_W-1:0] dec_ext;

    assign sum_ext = {1'b0, acc} + {1'b0, src} + {{WIDTH{1'b0}}, cin};
    assign inc_ext = {1'b0, opnd} + EXT_W'(1);
    // Top bit of the extended difference is the borrow out.
    assign dec_ext = {1'b0, opnd} - EXT_W'(1);

    always_comb begin
        data = '0;
        upd  = UPD_NONE;
        case (op)
            OP_ADC: begin
                data = sum_ext[WIDTH-1:0];
                upd  = upd_full(sum_ext[WIDTH], ~|sum_ext[WIDTH-1:0]);
            end
            OP_INC: begin
                data = inc_ext[WIDTH-1:0];
                upd  = upd_full(inc_ext[WIDTH], ~|inc_ext[WIDTH-1:0]);
            end
            OP_DEC: begin
                data = dec_ext[WIDTH-1:0];
                upd  = upd_full(dec_ext[WIDTH], ~|dec_ext[WIDTH-1:0]);
            end
            default: begin
                data = '0;
                upd  = UPD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] src,
    input  logic [WIDTH-1:0] opnd,
    output logic [WIDTH-1:0] data,
    output flag_upd_t        upd
);
    logic [WIDTH-1:0] and_v;
    logic [WIDTH-1:0] or_v;

    assign and_v = acc & src;
    assign or_v  = acc | src;

    always_comb begin
        data = '0;
        upd  = UPD_NONE;
        case (op)
            OP_AND: begin
                data = and_v;
                upd  = upd_full(1'b0, ~|and_v);
            end
            OP_OR: begin
                data = or_v;
                upd  = upd_full(1'b0, ~|or_v);
            end
            OP_CPL: begin
                data     = ~opnd;
                upd      = UPD_NONE;
                upd.rwe  = 1'b1;
            end
            default: begin
                data = '0;
                upd  = UPD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  op_e              op,
    input  logic [WIDTH-1:0] acc,
    input  logic             cin,
    output logic [WIDTH-1:0] data,
    output flag_upd_t        upd
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rol_v;
    logic [WIDTH-1:0] ror_v;
    logic [WIDTH-1:0] rlc_v;
    logic [WIDTH-1:0] rrc_v;

    // Bit-by-bit wiring of the four rotate networks.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rot
        if (i == 0) begin : g_lsb
            assign rol_v[i] = acc[MSB];
            assign rlc_v[i] = cin;
        end else begin : g_up
            assign rol_v[i] = acc[i-1];
            assign rlc_v[i] = acc[i-1];
        end
        if (i == MSB) begin : g_msb
            assign ror_v[i] = acc[0];
            assign rrc_v[i] = cin;
        end else begin : g_dn
            assign ror_v[i] = acc[i+1];
            assign rrc_v[i] = acc[i+1];
        end
    end

    always_comb begin
        data = '0;
        upd  = UPD_NONE;
        case (op)
            OP_RLC: begin
                data    = rlc_v;
                upd.c   = acc[MSB];
                upd.rwe = 1'b1;
                upd.cwe = 1'b1;
            end
            OP_RRC: begin
                data    = rrc_v;
                upd.c   = acc[0];
                upd.rwe = 1'b1;
                upd.cwe = 1'b1;
            end
            OP_ROL: begin
                data    = rol_v;
                upd.rwe = 1'b1;
            end
            OP_ROR: begin
                data    = ror_v;
                upd.rwe = 1'b1;
            end
            OP_CMC: begin
                upd.c   = ~cin;
                upd.cwe = 1'b1;
            end
            OP_CLC: begin
                upd.c   = 1'b0;
                upd.cwe = 1'b1;
            end
            default: begin
                data = '0;
                upd  = UPD_NONE;
            end
        endcase
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int IMM_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic             use_imm,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] opnd,
    input  logic [IMM_W-1:0] imm,
    input  logic             carry_in,
    input  logic             zero_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             result_we,
    output logic             carry_out,
    output logic             carry_we,
    output logic             zero_out,
    output logic             zero_we
);
    localparam int PAD_W = WIDTH - IMM_W;

    op_e              op_c;
    op_class_e        cls;
    logic [WIDTH-1:0] src;

    logic [WIDTH-1:0] ar_data, lg_data, sh_data, sel_data;
    flag_upd_t        ar_upd,  lg_upd,  sh_upd,  sel_upd;

    assign op_c = op_e'(op);
    assign cls  = class_of(op_c);
    assign src  = use_imm ? {{PAD_W{1'b0}}, imm} : opnd;

    acc_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .op(op_c), .acc(acc), .src(src), .opnd(opnd), .cin(carry_in),
        .data(ar_data), .upd(ar_upd)
    );

    acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .op(op_c), .acc(acc), .src(src), .opnd(opnd),
        .data(lg_data), .upd(lg_upd)
    );

    acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .op(op_c), .acc(acc), .cin(carry_in),
        .data(sh_data), .upd(sh_upd)
    );

    always_comb begin
        case (cls)
            CLS_ARITH: begin sel_data = ar_data; sel_upd = ar_upd; end
            CLS_LOGIC: begin sel_data = lg_data; sel_upd = lg_upd; end
            CLS_SHIFT: begin sel_data = sh_data; sel_upd = sh_upd; end
            default:   begin sel_data = acc;     sel_upd = UPD_NONE; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            result_we <= 1'b0;
            carry_out <= 1'b0;
            carry_we  <= 1'b0;
            zero_out  <= 1'b0;
            zero_we   <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result    <= sel_data;
                result_we <= sel_upd.rwe;
                carry_out <= sel_upd.cwe ? sel_upd.c : carry_in;
                carry_we  <= sel_upd.cwe;
                zero_out  <= sel_upd.zwe ? sel_upd.z : zero_in;
                zero_we   <= sel_upd.zwe;
            end else begin
                result_we <= 1'b0;
                carry_we  <= 1'b0;
                zero_we   <= 1'b0;
            end
        end
    end

    AST_IDLE_NO_WRITES: assert property (@(posedge clk) disable iff (rst) !out_valid |-> !(result_we || carry_we || zero_we)); // R12
    AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst) (out_valid && zero_we) |-> (zero_out == (result == '0))); // R11
    AST_CARRY_HELD: assert property (@(posedge clk) disable iff (rst) (out_valid && !carry_we) |-> (carry_out == $past(carry_in))); // R11
    AST_ZERO_HELD: assert property (@(posedge clk) disable iff (rst) (out_valid && !zero_we) |-> (zero_out == $past(zero_in))); // R11
    AST_CIRC_ROT_QUIET: assert property (@(posedge clk) disable iff (rst) ($past(in_valid) && ($past(op) == OP_ROL || $past(op) == OP_ROR)) |-> (!carry_we && !zero_we && $countones(result) == $countones($past(acc)))); // R9
    AST_LOGIC_CLEARS_CARRY: assert property (@(posedge clk) disable iff (rst) ($past(in_valid) && ($past(op) == OP_AND || $past(op) == OP_OR)) |-> (carry_we && !carry_out && zero_we)); // R6
    AST_CARRY_OPS_ONLY: assert property (@(posedge clk) disable iff (rst) ($past(in_valid) && ($past(op) == OP_CMC || $past(op) == OP_CLC)) |-> (carry_we && !result_we && !zero_we)); // R10
    AST_CPL_NO_FLAGS: assert property (@(posedge clk) disable iff (rst) ($past(in_valid) && $past(op) == OP_CPL) |-> (result_we && !carry_we && !zero_we)); // R7

endmodule

// File: tb/acc_alu_test.sv
module acc_alu_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] op = 4'h0;
    logic       use_imm = 1'b0;
    logic [7:0] acc = 8'h00;
    logic [7:0] opnd = 8'h00;
    logic [3:0] imm = 4'h0;
    logic       carry_in = 1'b0;
    logic       zero_in = 1'b0;
    logic       out_valid, result_we, carry_out, carry_we, zero_out, zero_we;
    logic [7:0] result;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    acc_alu uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op), .use_imm(use_imm),
        .acc(acc), .opnd(opnd), .imm(imm), .carry_in(carry_in), .zero_in(zero_in),
        .out_valid(out_valid), .result(result), .result_we(result_we),
        .carry_out(carry_out), .carry_we(carry_we), .zero_out(zero_out), .zero_we(zero_we)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Present one operation, then sample the registered outputs at the next falling edge.
    task automatic run_op(input logic [3:0] o, input logic ui, input logic [7:0] a,
                          input logic [7:0] b, input logic [3:0] im, input logic ci, input logic zi);
        @(negedge clk);
        in_valid = 1'b1; op = o; use_imm = ui; acc = a; opnd = b; imm = im;
        carry_in = ci; zero_in = zi;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic ev, input logic erwe, input logic [7:0] er,
                              input logic ec, input logic ecwe, input logic ez, input logic ezwe);
        bit bad;
        checks++;
        bad = (out_valid !== ev) || (result_we !== erwe) || (erwe && result !== er) ||
              (carry_out !== ec) || (carry_we !== ecwe) || (zero_out !== ez) || (zero_we !== ezwe);
        if (bad) begin
            failures++;
            $display("FAIL %s: actual v=%0b rwe=%0b r=%02h c=%0b cwe=%0b z=%0b zwe=%0b expected v=%0b rwe=%0b r=%02h c=%0b cwe=%0b z=%0b zwe=%0b",
                     req, out_valid, result_we, result, carry_out, carry_we, zero_out, zero_we,
                     ev, erwe, er, ec, ecwe, ez, ezwe);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        expect_out("R1 during reset", 0, 0, 8'h00, 0, 0, 0, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        expect_out("R1 after reset", 0, 0, 8'h00, 0, 0, 0, 0);
        checks++;
        if (result !== 8'h00) begin
            failures++;
            $display("FAIL R1 result reset actual=%02h expected=00", result);
        end
    endtask

    task automatic t_adc();
        run_op(4'h0, 0, 8'h7F, 8'h80, 4'h0, 1, 0);
        expect_out("R2 adc to 0x100", 1, 1, 8'h00, 1, 1, 1, 1);
        run_op(4'h0, 0, 8'h12, 8'h34, 4'h0, 0, 1);
        expect_out("R2 adc plain", 1, 1, 8'h46, 0, 1, 0, 1);
        run_op(4'h0, 0, 8'h10, 8'h20, 4'h0, 1, 0);
        expect_out("R2 adc carry in", 1, 1, 8'h31, 0, 1, 0, 1);
        run_op(4'h0, 0, 8'hFF, 8'hFF, 4'h0, 1, 0);
        expect_out("R2 adc max", 1, 1, 8'hFF, 1, 1, 0, 1);
    endtask

    task automatic t_imm();
        run_op(4'h0, 1, 8'hF0, 8'hAA, 4'hF, 1, 0);
        expect_out("R3 adc imm", 1, 1, 8'h00, 1, 1, 1, 1);
        run_op(4'h3, 1, 8'hFF, 8'h00, 4'h5, 0, 0);
        expect_out("R3 and imm", 1, 1, 8'h05, 0, 1, 0, 1);
        run_op(4'h4, 1, 8'h30, 8'hC0, 4'h3, 0, 0);
        expect_out("R3 or imm", 1, 1, 8'h33, 0, 1, 0, 1);
        run_op(4'h1, 1, 8'h00, 8'h10, 4'h7, 0, 0);
        expect_out("R3 inc ignores imm", 1, 1, 8'h11, 0, 1, 0, 1);
    endtask

    task automatic t_incdec();
        run_op(4'h1, 0, 8'h00, 8'hFF, 4'h0, 0, 0);
        expect_out("R4 inc wrap", 1, 1, 8'h00, 1, 1, 1, 1);
        run_op(4'h1, 0, 8'h00, 8'hFE, 4'h0, 1, 1);
        expect_out("R4 inc below wrap", 1, 1, 8'hFF, 0, 1, 0, 1);
        run_op(4'h2, 0, 8'h00, 8'h00, 4'h0, 0, 1);
        expect_out("R5 dec borrow", 1, 1, 8'hFF, 1, 1, 0, 1);
        run_op(4'h2, 0, 8'h00, 8'h01, 4'h0, 1, 0);
        expect_out("R5 dec to zero", 1, 1, 8'h00, 0, 1, 1, 1);
    endtask

    task automatic t_logic();
        run_op(4'h3, 0, 8'hF0, 8'h0F, 4'h0, 1, 0);
        expect_out("R6 and zero", 1, 1, 8'h00, 0, 1, 1, 1);
        run_op(4'h4, 0, 8'hA0, 8'h05, 4'h0, 1, 1);
        expect_out("R6 or", 1, 1, 8'hA5, 0, 1, 0, 1);
        run_op(4'h5, 1, 8'h00, 8'h5A, 4'hF, 1, 0);
        expect_out("R7 complement", 1, 1, 8'hA5, 1, 0, 0, 0);
        run_op(4'h5, 0, 8'h00, 8'hFF, 4'h0, 0, 1);
        expect_out("R7 complement to zero", 1, 1, 8'h00, 0, 0, 1, 0);
    endtask

    task automatic t_rotates();
        run_op(4'h6, 0, 8'h81, 8'h00, 4'h0, 0, 1);
        expect_out("R8 rlc", 1, 1, 8'h02, 1, 1, 1, 0);
        run_op(4'h6, 0, 8'h40, 8'h00, 4'h0, 1, 0);
        expect_out("R8 rlc carry in", 1, 1, 8'h81, 0, 1, 0, 0);
        run_op(4'h7, 0, 8'h01, 8'h00, 4'h0, 0, 0);
        expect_out("R8 rrc", 1, 1, 8'h00, 1, 1, 0, 0);
        run_op(4'h7, 0, 8'h02, 8'h00, 4'h0, 1, 1);
        expect_out("R8 rrc carry in", 1, 1, 8'h81, 0, 1, 1, 0);
        run_op(4'h8, 0, 8'h81, 8'h00, 4'h0, 0, 0);
        expect_out("R9 rol", 1, 1, 8'h03, 0, 0, 0, 0);
        run_op(4'h9, 0, 8'h01, 8'h00, 4'h0, 1, 1);
        expect_out("R9 ror", 1, 1, 8'h80, 1, 0, 1, 0);
    endtask

    task automatic t_carry_ops();
        run_op(4'hA, 0, 8'h55, 8'h00, 4'h0, 0, 1);
        expect_out("R10 invert carry 0", 1, 0, 8'h00, 1, 1, 1, 0);
        run_op(4'hA, 0, 8'h55, 8'h00, 4'h0, 1, 0);
        expect_out("R10 invert carry 1", 1, 0, 8'h00, 0, 1, 0, 0);
        run_op(4'hB, 0, 8'h55, 8'h00, 4'h0, 1, 1);
        expect_out("R10 clear carry", 1, 0, 8'h00, 0, 1, 1, 0);
    endtask

    task automatic t_reserved();
        for (int k = 12; k < 16; k++) begin
            run_op(4'(k), 0, 8'h3C, 8'hFF, 4'hF, 1, 1);
            expect_out("R11 reserved code", 1, 0, 8'h00, 1, 0, 1, 0);
        end
    endtask

    task automatic t_idle();
        @(negedge clk);
        in_valid = 1'b0; op = 4'h0; acc = 8'hFF; opnd = 8'h01;
        @(negedge clk);
        expect_out("R12 idle", 0, 0, 8'h00, carry_out, 0, zero_out, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_adc();
        t_imm();
        t_incdec();
        t_logic();
        t_rotates();
        t_carry_ops();
        t_reserved();
        t_idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule